// File: doc/BRIEF.md
# Handshaking Parallel Port

This block is one bidirectional parallel port seen by a processor through a small register window. Each line is set to drive or to listen by its own bit in a direction register. Lines set to drive show the output register. A read of the port returns the output register on driving lines and the input value on listening lines. The input value comes from the live pins, or from a copy taken when the peripheral signals that data is ready.

Two control lines serve the peripheral. `edge_in` is a strobe from the peripheral. It passes through a synchroniser before edge detection, and its active direction can be chosen. An active edge sets a sticky flag, `edge_flag`. `hs_out` is a line driven toward the peripheral. It can be a full handshake, a one-cycle pulse, or a fixed level. In the handshake and pulse modes, a processor access to the port register pulls it low. A second address reaches the same port register with no handshake action and no flag clear.

The processor interface is a plain single-cycle strobe. `bus_sel` with `bus_we` writes in that cycle. `bus_sel` without `bus_we` reads, and `bus_rdata` is valid combinationally while the strobe is high. There is no back-pressure: every strobe completes in its own cycle.

Top module: `hs_port`

## Requirements
- R1: After reset, the output register, the direction register and the 5-bit control register are all 0, `pin_oe` is 0, `hs_out` is 1 and `edge_flag` is 0.
- R2: A write to address 1 sets the direction register, and `pin_oe` equals it from the next cycle on. A write to address 0 or to address 3 sets the output register, and `pin_out` equals it from the next cycle on.
- R3: A read of address 0 or address 3 returns the output register bit on lines whose direction bit is 1, and the input bit on lines whose direction bit is 0. A read of address 2 returns the control register.
- R4: Control bit 4 enables input latching. When it is 1, the input value is the `pin_in` value captured in the cycle an active edge is detected, and it is held until the next active edge. When it is 0, the input value is the live `pin_in`.
- R5: Control bit 0 selects the active edge of `edge_in`: 1 means rising and 0 means falling. After an active transition, `edge_flag` is first seen high after the third rising clock edge, and it stays high until it is cleared. The other transition has no effect.
- R6: Any access to address 0 clears `edge_flag` at the next clock edge, unless an active edge is detected in that same cycle. An access to address 3 leaves the flag unchanged.
- R7: Control bits 3:1 = 000 selects read handshake. A read of address 0 makes `hs_out` low from the next cycle. It stays low until an active edge is detected, and it goes high at the same clock edge at which `edge_flag` sets.
- R8: Control bits 3:1 = 001 selects read pulse. A read of address 0 makes `hs_out` low for exactly one cycle.
- R9: Control bits 3:1 = 010 selects write handshake and 011 selects write pulse. These behave as R7 and R8, but they are triggered by a write of address 0. In these modes a read does not trigger them.
- R10: A read or a write of address 3 never changes `hs_out`.
- R11: Control bits 3:1 = 110 drives `hs_out` low and 111 drives it high. The value takes effect one cycle after the control register holds it. The codes 100 and 101 hold `hs_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 port, 1 direction, 2 control, 3 port without handshake |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the strobe is high |
| pin_in | input | 8 | Peripheral line input values |
| pin_out | output | 8 | Output register toward the lines |
| pin_oe | output | 8 | Per-line drive enable (direction register) |
| edge_in | input | 1 | Peripheral strobe (asynchronous) |
| hs_out | output | 1 | Handshake, pulse or manual line toward the peripheral |
| edge_flag | output | 1 | Sticky active-edge flag |

## Verification
Read data is due in the strobe cycle itself. The scoreboard monitor samples it 5 ns after the falling clock edge that opened the strobe. Register writes and `hs_out` triggers take effect one edge later, so the bench checks them at the falling edge that closes the access. An active `edge_in` transition driven at a falling edge is due after the third rising edge. The bench therefore checks that `edge_flag` and `hs_out` are still unchanged after two cycles and have changed after three. A pulse is checked as low one cycle after the access and high one cycle later.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

  localparam int CTL_W = 5;

  localparam logic [1:0] ADDR_PORT  = 2'd0;
  localparam logic [1:0] ADDR_DIR   = 2'd1;
  localparam logic [1:0] ADDR_CTL   = 2'd2;
  localparam logic [1:0] ADDR_ALIAS = 2'd3;

  typedef enum logic [2:0] {
    HS_RD_HAND  = 3'b000,
    HS_RD_PULSE = 3'b001,
    HS_WR_HAND  = 3'b010,
    HS_WR_PULSE = 3'b011,
    HS_IDLE_A   = 3'b100,
    HS_IDLE_B   = 3'b101,
    HS_MAN_LO   = 3'b110,
    HS_MAN_HI   = 3'b111
  } hs_mode_e;

  typedef struct packed {
    logic     latch_en;
    hs_mode_e mode;
    logic     edge_rise;
  } ctl_t;

endpackage

// File: rtl/hs_edge_sync.sv
module hs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  input  logic rise_sel,
  output logic edge_pulse
);
  localparam int TOP = STAGES;

  logic [TOP:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[TOP-1:0], edge_in};
  end

  logic now_lvl, was_lvl;
  assign now_lvl = chain_q[TOP-1];
  assign was_lvl = chain_q[TOP];

  assign edge_pulse = rise_sel ? (now_lvl & ~was_lvl) : (~now_lvl & was_lvl);

endmodule

// File: rtl/hs_out_ctl.sv
module hs_out_ctl
  import hs_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hs_mode_e mode,
  input  logic     rd_trig,
  input  logic     wr_trig,
  input  logic     edge_pulse,
  output logic     hs_out
);

  logic hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
    end else begin
      unique case (mode)
        HS_RD_HAND:  hs_q <= rd_trig ? 1'b0 : (edge_pulse ? 1'b1 : hs_q);
        HS_RD_PULSE: hs_q <= ~rd_trig;
        HS_WR_HAND:  hs_q <= wr_trig ? 1'b0 : (edge_pulse ? 1'b1 : hs_q);
        HS_WR_PULSE: hs_q <= ~wr_trig;
        HS_MAN_LO:   hs_q <= 1'b0;
        HS_MAN_HI:   hs_q <= 1'b1;
        default:     hs_q <= 1'b1;
      endcase
    end
  end

  assign hs_out = hs_q;

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HS_RD_HAND && !hs_out && !edge_pulse) |=> !hs_out);

  // R8
  pulse_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HS_RD_PULSE && !hs_out && !rd_trig) |=> hs_out);

  // R11
  manual_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HS_MAN_LO) |=> !hs_out);

endmodule

// File: rtl/hs_port_regs.sv
module hs_port_regs
  import hs_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_out,
  input  logic             wr_dir,
  input  logic             wr_ctl,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             edge_pulse,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output ctl_t             ctl_q,
  output logic [WIDTH-1:0] rd_port
);

  logic [WIDTH-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      ctl_q <= '0;
      cap_q <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      if (wr_ctl) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
      if (edge_pulse) cap_q <= pin_in;
    end
  end

  logic [WIDTH-1:0] in_val;
  assign in_val = ctl_q.latch_en ? cap_q : pin_in;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign rd_port[b] = dir_q[b] ? out_q[b] : in_val[b];
  end

  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.latch_en && !edge_pulse && !wr_dir && !wr_ctl && dir_q == '0)
      |=> $stable(rd_port));

endmodule

// File: rtl/hs_port.sv
module hs_port
  import hs_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             edge_in,
  output logic             hs_out,
  output logic             edge_flag
);

  logic hit_port, hit_alias, hit_dir, hit_ctl;
  assign hit_port  = bus_sel && bus_addr == ADDR_PORT;
  assign hit_alias = bus_sel && bus_addr == ADDR_ALIAS;
  assign hit_dir   = bus_sel && bus_addr == ADDR_DIR;
  assign hit_ctl   = bus_sel && bus_addr == ADDR_CTL;

  logic             edge_pulse;
  logic [WIDTH-1:0] out_q, dir_q, rd_port;
  ctl_t             ctl_q;

  hs_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_in    (edge_in),
    .rise_sel   (ctl_q.edge_rise),
    .edge_pulse (edge_pulse)
  );

  hs_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_out     (bus_we && (hit_port || hit_alias)),
    .wr_dir     (bus_we && hit_dir),
    .wr_ctl     (bus_we && hit_ctl),
    .wdata      (bus_wdata),
    .pin_in     (pin_in),
    .edge_pulse (edge_pulse),
    .out_q      (out_q),
    .dir_q      (dir_q),
    .ctl_q      (ctl_q),
    .rd_port    (rd_port)
  );

  hs_out_ctl u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (ctl_q.mode),
    .rd_trig    (hit_port && !bus_we),
    .wr_trig    (hit_port && bus_we),
    .edge_pulse (edge_pulse),
    .hs_out     (hs_out)
  );

  logic flag_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (edge_pulse) flag_q <= 1'b1;
    else if (hit_port)   flag_q <= 1'b0;
  end
  assign edge_flag = flag_q;

  always_comb begin
    unique case (bus_addr)
      ADDR_DIR: bus_rdata = dir_q;
      ADDR_CTL: bus_rdata = WIDTH'(ctl_q);
      default:  bus_rdata = rd_port;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_DIR) |=> pin_oe == $past(bus_wdata));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && !(bus_sel && bus_addr == ADDR_PORT)) |=> edge_flag);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == ADDR_PORT && !edge_pulse) |=> !edge_flag);

  // R10
  alias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == ADDR_ALIAS && ctl_q.mode == HS_WR_HAND && !edge_pulse)
      |=> $stable(hs_out));

endmodule

// File: tb/hs_port_test.sv
module hs_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  logic       edge_in = 1'b1;
  logic       hs_out, edge_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  hs_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .edge_in(edge_in), .hs_out(hs_out), .edge_flag(edge_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data while a read strobe is open
  always @(negedge clk) begin
    #5;
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata == e, t, bus_rdata, e);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0, "R1", {pin_oe, pin_out}, 0);
    chk(hs_out == 1 && edge_flag == 0, "R1", {hs_out, edge_flag}, 2);
    bus_rd(2'd2, 8'h00, "R1 ctl");

    // R2 direction and output
    bus_wr(2'd1, 8'hF0);
    chk(pin_oe == 8'hF0, "R2", pin_oe, 8'hF0);
    bus_wr(2'd0, 8'hA5);
    chk(pin_out == 8'hA5, "R2", pin_out, 8'hA5);

    // R3 mixed read, R10 alias read has no handshake
    pin_in = 8'h3C;
    bus_rd(2'd3, 8'hAC, "R3 alias");
    chk(hs_out == 1, "R10", hs_out, 1);
    bus_rd(2'd1, 8'hF0, "R3 dir");

    // R7 read handshake, R5 falling edge timing
    bus_rd(2'd0, 8'hAC, "R3 port");
    chk(hs_out == 0, "R7", hs_out, 0);
    idle(2);
    chk(hs_out == 0, "R7", hs_out, 0);
    edge_in = 0;
    idle(2);
    chk(edge_flag == 0 && hs_out == 0, "R5", {edge_flag, hs_out}, 0);
    idle(1);
    chk(edge_flag == 1, "R5", edge_flag, 1);
    chk(hs_out == 1, "R7", hs_out, 1);

    // R6 alias keeps flag, port access clears it
    bus_rd(2'd3, 8'hAC, "R6 alias");
    chk(edge_flag == 1, "R6", edge_flag, 1);
    bus_rd(2'd0, 8'hAC, "R6 port");
    chk(edge_flag == 0, "R6", edge_flag, 0);

    // R8 read pulse
    bus_wr(2'd2, 8'h02);
    idle(2);
    chk(hs_out == 1, "R8", hs_out, 1);
    bus_rd(2'd0, 8'hAC, "R8 read");
    chk(hs_out == 0, "R8", hs_out, 0);
    idle(1);
    chk(hs_out == 1, "R8", hs_out, 1);

    // R9 write handshake, rising edge select
    bus_wr(2'd2, 8'h05);
    idle(1);
    bus_rd(2'd0, 8'hAC, "R9 read");
    chk(hs_out == 1, "R9", hs_out, 1);
    bus_wr(2'd0, 8'h11);
    chk(hs_out == 0, "R9", hs_out, 0);
    bus_wr(2'd3, 8'h44);
    chk(hs_out == 0 && pin_out == 8'h44, "R10", {hs_out, pin_out}, 8'h44);
    edge_in = 1;
    idle(3);
    chk(hs_out == 1 && edge_flag == 1, "R9", {hs_out, edge_flag}, 3);
    bus_wr(2'd0, 8'h11);
    chk(hs_out == 0 && edge_flag == 0, "R6", {hs_out, edge_flag}, 0);
    edge_in = 0;
    idle(3);
    chk(hs_out == 0 && edge_flag == 0, "R5", {hs_out, edge_flag}, 0);
    edge_in = 1;
    idle(3);
    chk(hs_out == 1, "R9", hs_out, 1);

    // R9 write pulse, R10 alias write
    bus_wr(2'd2, 8'h07);
    idle(1);
    bus_wr(2'd3, 8'h22);
    chk(hs_out == 1 && pin_out == 8'h22, "R10", {hs_out, pin_out}, 9'h122);
    bus_wr(2'd0, 8'h33);
    chk(hs_out == 0, "R9", hs_out, 0);
    idle(1);
    chk(hs_out == 1, "R9", hs_out, 1);

    // R11 manual levels
    bus_wr(2'd2, 8'h0C);
    idle(1);
    chk(hs_out == 0, "R11", hs_out, 0);
    bus_wr(2'd2, 8'h0E);
    idle(1);
    chk(hs_out == 1, "R11", hs_out, 1);
    bus_wr(2'd2, 8'h08);
    idle(1);
    chk(hs_out == 1, "R11", hs_out, 1);

    // R4 latching on rising edge
    bus_wr(2'd2, 8'h11);
    bus_wr(2'd1, 8'h00);
    pin_in = 8'h5A;
    edge_in = 0;
    idle(3);
    edge_in = 1;
    idle(3);
    pin_in = 8'hFF;
    bus_rd(2'd3, 8'h5A, "R4 latched");
    bus_rd(2'd2, 8'h11, "R3 ctl");
    bus_wr(2'd2, 8'h01);
    bus_rd(2'd3, 8'hFF, "R4 live");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule